// File: doc/BRIEF.md
# Serial Configuration Bitstream Streamer

This block is the memory end of a passive serial configuration link. It keeps a small byte image of parameterised length and, when asked, sends it one bit at a time to a receiving device over a data line and a configuration clock. It makes that clock itself by dividing its own system clock, so the receiver does not supply one.

Streaming is controlled by two handshake inputs and needs no length exchange. A low-to-high transition on the enable input `start_en` starts a transfer while the active-low select `sel_n` is low. The receiver's done line is wired to `sel_n`. When that line goes high, the streamer stops clocking and releases both outputs. Once the image has been sent, the block keeps sending 1 bits until the stop arrives.

The image is written through a small parallel port while the block is idle. It can instead be preloaded at reset from a seed parameter.

Top module: `cfg_bitstream_streamer`

## Requirements
- R1: A transfer begins only at a clock edge where `start_en` is sampled high after being sampled low at the edge before, and `sel_n` is sampled low. From the next cycle, `cfg_clk_en` and `cfg_dat_en` are high. Holding `start_en` high does not start a transfer, and neither does lowering `sel_n` while `start_en` is already high.
- R2: `cfg_dat` carries one bit per `cfg_clk` period. Bytes go out in increasing address order, and each byte is sent least significant bit first (bit 0 of byte 0 is the first bit).
- R3: `cfg_dat` changes only where `cfg_clk` falls. It stays stable for the whole high phase, so the receiver's rising-edge sample sees settled data.
- R4: `cfg_clk` runs at the system clock frequency divided by `CLK_DIV`, which must be even and at least 2. The high and low phases are each `CLK_DIV/2` cycles long, and a transfer starts with a low phase.
- R5: If `sel_n` is sampled high during a transfer, `cfg_clk_en` and `cfg_dat_en` go low in the next cycle and `cfg_clk` holds low. They stay that way until `start_en` goes low, even if `sel_n` returns low.
- R6: After the last stored bit has had its full period, `cfg_dat` is 1 in every following period and `img_done` is high. `img_done` is low while stored bits are still being sent.
- R7: When `start_en` is sampled low, the block returns to idle in the next cycle. The bit pointer goes back to zero, `cfg_clk` is low and both enables are low. A later rise of `start_en` sends the image again from the first bit.
- R8: A cycle with `img_we` high while the block is idle stores `img_wdata` at byte `img_addr`. Writes made while a transfer is running or halted are ignored.
- R9: With `PRELOAD`=1, reset loads byte i with `SEED ^ ((i*29 + 3) mod 256)`. With `PRELOAD`=0, reset clears every byte to zero.
- R10: During and right after reset, `cfg_clk`, `cfg_clk_en`, `cfg_dat`, `cfg_dat_en` and `img_done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the source of the configuration clock |
| rst_n | input | 1 | Active-low synchronous reset |
| img_we | input | 1 | Image write strobe, accepted while idle |
| img_addr | input | AW | Byte address for an image write |
| img_wdata | input | 8 | Byte value for an image write |
| start_en | input | 1 | Enable; a rising edge starts a transfer, a low level returns the block to idle |
| sel_n | input | 1 | Active-low select, driven by the receiver's done line |
| cfg_clk | output | 1 | Generated configuration clock |
| cfg_clk_en | output | 1 | Drive enable for `cfg_clk`; low means released |
| cfg_dat | output | 1 | Serial configuration data |
| cfg_dat_en | output | 1 | Drive enable for `cfg_dat`; low means released |
| img_done | output | 1 | Every stored bit has been sent |

## Verification
The bench builds the streamer with a four-byte image, `CLK_DIV`=4 and `PRELOAD`=1 with a fixed seed. This keeps one full transfer, plus a few trailing fill bits, to about 150 cycles. That makes it cheap to first check the seeded reset image and then to send 64 images that together cover every one of the 256 byte values, comparing each received bit with a value worked out from its address and bit position. The small divider lets every clock phase have its length measured. The short image also brings into reach, within a few hundred cycles, the transition to `img_done`, a stop by `sel_n`, an abort by `start_en`, a write made during a transfer, and blocked starts.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_HALT = 2'd2
   } stream_state_e;

   // Reset image value for byte idx when preloading from a seed.
   function automatic logic [7:0] image_byte(input logic [7:0] seed, input int unsigned idx);
      logic [7:0] i8;
      i8 = idx[7:0];
      return seed ^ (i8 * 8'd29 + 8'd3);
   endfunction

endpackage

// File: rtl/cfg_image_store.sv
module cfg_image_store
   import cfg_stream_pkg::*;
#(
   parameter int unsigned DEPTH   = 16,
   parameter int unsigned AW      = 4,
   parameter bit          PRELOAD = 1'b1,
   parameter logic [7:0]  SEED    = 8'h5A
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_allow,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   input  logic [AW-1:0] rd_idx,
   output logic [7:0]    rd_data
);

   logic [7:0] init_val [DEPTH];
   logic [7:0] mem_q    [DEPTH];

   // Reset contents: seeded pattern or all zeros, chosen at elaboration.
   generate
      if (PRELOAD) begin : g_seeded
         for (genvar gi = 0; gi < int'(DEPTH); gi++) begin : g_ent
            assign init_val[gi] = image_byte(SEED, gi);
         end
      end else begin : g_cleared
         for (genvar gi = 0; gi < int'(DEPTH); gi++) begin : g_ent
            assign init_val[gi] = 8'h00;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= init_val[i];
      end else if (wr_en && wr_allow) begin
         for (int i = 0; i < int'(DEPTH); i++) begin
            if (wr_addr == AW'(i)) mem_q[i] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = 8'h00;
      for (int i = 0; i < int'(DEPTH); i++) begin
         if (rd_idx == AW'(i)) rd_data = mem_q[i];
      end
   end

endmodule

// File: rtl/cfg_clk_divider.sv
module cfg_clk_divider #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk,
   output logic wrap
);

   localparam int unsigned CW   = (DIV > 2) ? $clog2(DIV) : 1;
   localparam int unsigned HALF = DIV / 2;

   logic [CW-1:0] cnt_q;

   assign wrap = run && (cnt_q == CW'(DIV - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (!run || wrap) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end

   // Low half first, then high half; the period boundary is a falling edge.
   generate
      if (DIV == 2) begin : g_div2
         assign sclk = run & cnt_q[0];
      end else begin : g_divn
         assign sclk = run && (cnt_q >= CW'(HALF));
      end
   endgenerate

endmodule

// File: rtl/cfg_stream_ctrl.sv
module cfg_stream_ctrl
   import cfg_stream_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned AW    = 4,
   parameter int unsigned PW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_en,
   input  logic          sel_n,
   input  logic          wrap,
   output logic          run,
   output logic          wr_allow,
   output logic          done,
   output logic [AW-1:0] byte_idx,
   output logic [2:0]    bit_sel
);

   localparam logic [PW-1:0] LAST = PW'(DEPTH * 8);

   stream_state_e state_q;
   logic          en_q;
   logic [PW-1:0] ptr_q;
   logic          en_rise;

   assign en_rise = start_en && !en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         en_q    <= 1'b0;
         ptr_q   <= '0;
      end else begin
         en_q <= start_en;
         if (!start_en) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
         end else begin
            unique case (state_q)
               ST_IDLE: begin
                  if (en_rise && !sel_n) begin
                     state_q <= ST_RUN;
                     ptr_q   <= '0;
                  end
               end
               ST_RUN: begin
                  if (sel_n)                       state_q <= ST_HALT;
                  else if (wrap && ptr_q != LAST)  ptr_q   <= ptr_q + 1'b1;
               end
               ST_HALT: state_q <= ST_HALT;
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign run      = (state_q == ST_RUN);
   assign wr_allow = (state_q == ST_IDLE);
   assign done     = (ptr_q == LAST);
   assign byte_idx = ptr_q[AW+2:3];
   assign bit_sel  = ptr_q[2:0];

endmodule

// File: rtl/cfg_bitstream_streamer.sv
module cfg_bitstream_streamer #(
   parameter int unsigned DEPTH   = 16,
   parameter int unsigned CLK_DIV = 4,
   parameter bit          PRELOAD = 1'b1,
   parameter logic [7:0]  SEED    = 8'h5A,
   localparam int unsigned AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          img_we,
   input  logic [AW-1:0] img_addr,
   input  logic [7:0]    img_wdata,
   input  logic          start_en,
   input  logic          sel_n,
   output logic          cfg_clk,
   output logic          cfg_clk_en,
   output logic          cfg_dat,
   output logic          cfg_dat_en,
   output logic          img_done
);

   localparam int unsigned PW = $clog2(DEPTH * 8 + 1);

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("cfg_bitstream_streamer: CLK_DIV must be even and at least 2");
      end
      if (DEPTH < 1 || DEPTH > 256) begin : g_bad_depth
         $error("cfg_bitstream_streamer: DEPTH must lie in 1..256");
      end
   endgenerate

   logic          run, wr_allow, done, wrap, sclk;
   logic [AW-1:0] byte_idx;
   logic [2:0]    bit_sel;
   logic [7:0]    cur_byte;

   cfg_stream_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_en (start_en),
      .sel_n    (sel_n),
      .wrap     (wrap),
      .run      (run),
      .wr_allow (wr_allow),
      .done     (done),
      .byte_idx (byte_idx),
      .bit_sel  (bit_sel)
   );

   cfg_clk_divider #(.DIV(CLK_DIV)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .sclk  (sclk),
      .wrap  (wrap)
   );

   cfg_image_store #(.DEPTH(DEPTH), .AW(AW), .PRELOAD(PRELOAD), .SEED(SEED)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_allow (wr_allow),
      .wr_en    (img_we),
      .wr_addr  (img_addr),
      .wr_data  (img_wdata),
      .rd_idx   (byte_idx),
      .rd_data  (cur_byte)
   );

   assign cfg_clk    = sclk;
   assign cfg_clk_en = run;
   assign cfg_dat_en = run;
   assign cfg_dat    = run && (done ? 1'b1 : cur_byte[bit_sel]);
   assign img_done   = done;

endmodule

// File: rtl/cfg_streamer_checker.sv
module cfg_streamer_checker #(
   parameter int unsigned HALF = 2
) (
   input logic clk,
   input logic rst_n,
   input logic start_en,
   input logic sel_n,
   input logic cfg_clk,
   input logic cfg_clk_en,
   input logic cfg_dat,
   input logic cfg_dat_en,
   input logic img_done
);

   localparam int unsigned RW = $clog2(HALF + 2);

   logic [RW-1:0] hi_run;

   always_ff @(posedge clk) begin
      if (!rst_n)                       hi_run <= '0;
      else if (!cfg_clk)                hi_run <= '0;
      else if (hi_run != RW'(HALF + 1)) hi_run <= hi_run + 1'b1;
   end

   p_start_on_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_clk_en) |-> $past(start_en) && !$past(sel_n));

   p_data_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_clk && $past(cfg_clk)) |-> $stable(cfg_dat));

   p_high_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cfg_clk) && cfg_clk_en) |-> (hi_run == RW'(HALF)));

   p_sel_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_n && cfg_clk_en) |=> (!cfg_clk_en && !cfg_dat_en && !cfg_clk));

   p_fill_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (img_done && cfg_dat_en) |-> cfg_dat);

   p_idle_on_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !start_en |=> (!cfg_clk && !cfg_clk_en && !cfg_dat_en && !img_done));

   p_clk_only_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_clk |-> cfg_clk_en);

endmodule

bind cfg_bitstream_streamer cfg_streamer_checker #(.HALF(CLK_DIV / 2)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_en   (start_en),
   .sel_n      (sel_n),
   .cfg_clk    (cfg_clk),
   .cfg_clk_en (cfg_clk_en),
   .cfg_dat    (cfg_dat),
   .cfg_dat_en (cfg_dat_en),
   .img_done   (img_done)
);

// File: tb/tb_cfg_bitstream_streamer.sv
module tb_cfg_bitstream_streamer;

   localparam int   CLK_PERIOD = 10;
   localparam int   DEPTH      = 4;
   localparam int   DIV        = 4;
   localparam int   NBITS      = DEPTH * 8;
   localparam logic [7:0] SEED = 8'hA5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       img_we = 1'b0;
   logic [1:0] img_addr = '0;
   logic [7:0] img_wdata = '0;
   logic       start_en = 1'b0;
   logic       sel_n = 1'b0;
   logic       cfg_clk, cfg_clk_en, cfg_dat, cfg_dat_en, img_done;

   int n_chk = 0;
   int n_err = 0;
   logic [7:0] exp_img [DEPTH];

   always #(CLK_PERIOD / 2) clk = ~clk;

   cfg_bitstream_streamer #(.DEPTH(DEPTH), .CLK_DIV(DIV), .PRELOAD(1'b1), .SEED(SEED)) dut (
      .clk(clk), .rst_n(rst_n), .img_we(img_we), .img_addr(img_addr), .img_wdata(img_wdata),
      .start_en(start_en), .sel_n(sel_n), .cfg_clk(cfg_clk), .cfg_clk_en(cfg_clk_en),
      .cfg_dat(cfg_dat), .cfg_dat_en(cfg_dat_en), .img_done(img_done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   task automatic write_byte(input int a, input logic [7:0] d);
      @(negedge clk);
      img_we = 1'b1; img_addr = 2'(a); img_wdata = d;
      @(negedge clk);
      img_we = 1'b0;
   endtask

   // Raise start_en, then capture nb bits at rising cfg_clk and check them,
   // together with the phase lengths and the done flag.
   task automatic run_stream(input int nb);
      int got = 0;
      int guard = 0;
      int run_len = 0;
      bit seen_rise = 0;
      logic prev = 1'b0;
      @(negedge clk);
      start_en = 1'b1;
      while (got < nb && guard < 400) begin
         @(negedge clk);
         guard++;
         if (cfg_clk == prev) run_len++;
         else begin
            if (seen_rise) chk(run_len == DIV / 2, "R4 phase length", run_len, DIV / 2);
            run_len = 1;
         end
         if (cfg_clk && !prev) begin
            logic e;
            e = (got < NBITS) ? exp_img[got / 8][got % 8] : 1'b1;
            chk(cfg_dat === e, (got < NBITS) ? "R2 data bit" : "R6 fill bit", int'(cfg_dat), int'(e));
            if (got == NBITS - 1) chk(img_done === 1'b0, "R6 done early", int'(img_done), 0);
            if (got == NBITS)     chk(img_done === 1'b1, "R6 done set", int'(img_done), 1);
            got++;
            seen_rise = 1;
         end
         prev = cfg_clk;
      end
      chk(got == nb, "R1 transfer ran", got, nb);
   endtask

   task automatic stop_and_idle();
      @(negedge clk);
      sel_n = 1'b1;
      @(negedge clk);
      chk(cfg_clk_en === 1'b0 && cfg_dat_en === 1'b0, "R5 released", int'(cfg_clk_en), 0);
      start_en = 1'b0;
      sel_n = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
      summary();
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) exp_img[i] = SEED ^ 8'((i * 29 + 3) % 256);

      repeat (3) @(negedge clk);
      // R10: reset values
      chk({cfg_clk, cfg_clk_en, cfg_dat, cfg_dat_en, img_done} == 5'b0, "R10 in reset",
          int'({cfg_clk, cfg_clk_en, cfg_dat, cfg_dat_en, img_done}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({cfg_clk, cfg_clk_en, cfg_dat, cfg_dat_en, img_done} == 5'b0, "R10 after reset",
          int'({cfg_clk, cfg_clk_en, cfg_dat, cfg_dat_en, img_done}), 0);

      // R9: seeded image from reset
      run_stream(NBITS + 4);
      // R5: held stop keeps the outputs released even after sel_n returns low
      @(negedge clk);
      sel_n = 1'b1;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         chk(cfg_clk === 1'b0 && cfg_clk_en === 1'b0, "R5 halted", int'(cfg_clk_en), 0);
      end
      sel_n = 1'b0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         chk(cfg_clk_en === 1'b0 && cfg_dat_en === 1'b0, "R5 stays halted", int'(cfg_clk_en), 0);
      end
      start_en = 1'b0;
      @(negedge clk);

      // R2/R8: sweep all 256 byte values through the image
      for (int v = 0; v < 64; v++) begin
         for (int a = 0; a < DEPTH; a++) begin
            exp_img[a] = 8'(v * 4 + a);
            write_byte(a, exp_img[a]);
         end
         run_stream(NBITS + 3);
         stop_and_idle();
      end

      // R7: abort mid-stream by dropping start_en, then restart from bit 0
      run_stream(10);
      @(negedge clk);
      start_en = 1'b0;
      @(negedge clk);
      chk(cfg_clk === 1'b0 && cfg_clk_en === 1'b0 && img_done === 1'b0, "R7 idle after drop",
          int'({cfg_clk, cfg_clk_en, img_done}), 0);
      run_stream(NBITS + 2);
      stop_and_idle();

      // R1: no start while sel_n high, nor when sel_n falls with start_en held high
      @(negedge clk);
      sel_n = 1'b1;
      start_en = 1'b1;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         chk(cfg_clk_en === 1'b0, "R1 blocked by sel_n", int'(cfg_clk_en), 0);
      end
      sel_n = 1'b0;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         chk(cfg_clk_en === 1'b0, "R1 no rise no start", int'(cfg_clk_en), 0);
      end
      start_en = 1'b0;
      @(negedge clk);

      // R8: a write during a transfer is ignored
      @(negedge clk);
      start_en = 1'b1;
      repeat (6) @(negedge clk);
      img_we = 1'b1; img_addr = 2'd0; img_wdata = ~exp_img[0];
      @(negedge clk);
      img_we = 1'b0;
      stop_and_idle();
      run_stream(NBITS + 1);
      stop_and_idle();

      summary();
   end

endmodule